// File: doc/BRIEF.md
# GPIO Function Select Multiplexer

This block drives one general-purpose output pin. A control register picks the source: a jack-insert flag, a temperature-ok flag, an auto-mute-active flag, a PLL-lock flag, or a clock made from the PLL output clock. The register also holds a polarity invert bit and a setting that divides the clock by 1, 2, 3 or 4. For the "off" code and for the two unused codes, the output-enable is low and the pin value is held at 0.

The whole block runs on one clock, `clk`, which is the PLL output clock. Register writes are timed by this clock, and the divider counts its rising edges. Software writes a word on the plain write strobe, which has no handshake. The word is taken only when the address matches `CTRL_ADDR`. The status flags feed the output mux combinationally, so a change on a flag reaches the pin in the same cycle. A register change reaches the pin just after the clock edge that captures it. When the divide-by-1 clock source is selected, `clk` itself is passed to the pin. No data stream passes through the block, so it has no valid/ready interface.

Top module: `gpio_func_mux`

## Requirements
- R1: After reset, all register fields are 0, `gpio_oe` is 0, `gpio_out` is 0 and the divider ratio is 1.
- R2: On a rising edge where `wr_en` is 1 and `wr_addr` equals `CTRL_ADDR` (default 8), the register takes new values from the data word: select from `wr_data[2:0]`, invert from `wr_data[3]` and divider from `wr_data[5:4]`. The other data bits are ignored, and a write to any other address changes nothing.
- R3: For select codes 000, 110 and 111, `gpio_oe` is 0 and `gpio_out` is 0, whatever the invert bit holds.
- R4: For select codes 001 to 101, `gpio_oe` is 1.
- R5: Code 010 passes `temp_ok`, code 011 passes `amute_act` and code 101 passes `pll_lock` to the pin.
- R6: Code 001 passes `jack_det` only while `slow_clk_en` is 1. While `slow_clk_en` is 0, the source reads as 0.
- R7: When the invert bit is 1, the pin shows the complement of the selected source for every active code, including the clock source.
- R8: Code 100 with divider setting 00 makes `gpio_out` follow `clk` (inverted when the invert bit is 1).
- R9: With divider setting 01 the clock source is high for 1 of every 2 cycles. With 11 it is high for 2 of every 4. With 10 it is high for 1 of every 3. Each period starts with its high phase.
- R10: A new divider setting takes effect only at the end of the current output period. The next period then starts from its high phase, so no shortened pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PLL output clock; times register writes and the divider |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (7) | Register address of the write |
| wr_data | input | DATA_W (16) | Register write data |
| jack_det | input | 1 | Jack-insert detect flag |
| slow_clk_en | input | 1 | Slow-clock enable; must be 1 for the jack detect source to pass |
| temp_ok | input | 1 | Temperature-ok flag |
| amute_act | input | 1 | Auto-mute-active flag |
| pll_lock | input | 1 | PLL lock flag |
| gpio_out | output | 1 | Pin output value |
| gpio_oe | output | 1 | Pin output-enable |

## Verification
The assertions run on every cycle. They check:
- that the pin is 0 whenever the output-enable is low;
- the jack gate while the slow-clock enable is low;
- that a matching write lands in the register;
- that the divider counter stays within the active ratio;
- that the active ratio changes only at the end of a period;
- that a divide-by-3 high phase lasts exactly one cycle.

The bench's reference model compares both clock phases in every cycle. This is the only way to show the divide-by-1 pass-through of `clk`, the duty cycle of each ratio, that inversion reaches the clock source, and that writes to other addresses or to upper data bits have no effect.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
  // Function select codes for the pin source.
  typedef enum logic [2:0] {
    SEL_OFF   = 3'd0,
    SEL_JACK  = 3'd1,
    SEL_TEMP  = 3'd2,
    SEL_AMUTE = 3'd3,
    SEL_CLK   = 3'd4,
    SEL_LOCK  = 3'd5,
    SEL_RSV6  = 3'd6,
    SEL_RSV7  = 3'd7
  } gpio_sel_e;

  localparam int DIV_W = 2;

  // Field order follows the register layout: div [5:4], inv [3], sel [2:0].
  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             inv;
    gpio_sel_e        sel;
  } gpio_cfg_t;

  localparam int CFG_W = $bits(gpio_cfg_t);
endpackage

// File: rtl/gpio_ctrl_reg.sv
module gpio_ctrl_reg
  import gpio_mux_pkg::*;
#(
  parameter int              ADDR_W    = 7,
  parameter int              DATA_W    = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 7'd8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output gpio_cfg_t         cfg_o
);
  logic hit;
  logic unused_hi;

  assign hit       = wr_en && (wr_addr == CTRL_ADDR);
  assign unused_hi = ^wr_data[DATA_W-1:CFG_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_o <= '0;
    end else if (hit) begin
      cfg_o <= gpio_cfg_t'(wr_data[CFG_W-1:0]);
    end
  end
endmodule

// File: rtl/gpio_clk_div.sv
module gpio_clk_div #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_set,
  output logic             clk_o,
  output logic             hi_o,
  output logic [DIV_W-1:0] act_o,
  output logic [DIV_W-1:0] cnt_o
);
  localparam int RW = DIV_W + 1;

  logic [DIV_W-1:0] act_q;
  logic [DIV_W-1:0] cnt_q;
  logic             wrap;
  logic [RW-1:0]    ratio;
  logic [RW-1:0]    hi_len;

  // The counter runs 0 .. ratio-1. A new ratio is loaded only at the wrap.
  assign wrap   = (cnt_q == act_q);
  assign ratio  = RW'(act_q) + RW'(1);
  assign hi_len = ratio >> 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      cnt_q <= '0;
    end else if (wrap) begin
      act_q <= div_set;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign hi_o  = (RW'(cnt_q) < hi_len);
  assign clk_o = (act_q == '0) ? clk : hi_o;
  assign act_o = act_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/gpio_src_mux.sv
module gpio_src_mux
  import gpio_mux_pkg::*;
(
  input  gpio_cfg_t cfg,
  input  logic      jack_det,
  input  logic      slow_clk_en,
  input  logic      temp_ok,
  input  logic      amute_act,
  input  logic      pll_lock,
  input  logic      clk_src,
  output logic      pin_o,
  output logic      oe_o
);
  logic src;

  always_comb begin
    src  = 1'b0;
    oe_o = 1'b1;
    unique case (cfg.sel)
      SEL_JACK:  src = jack_det & slow_clk_en;
      SEL_TEMP:  src = temp_ok;
      SEL_AMUTE: src = amute_act;
      SEL_CLK:   src = clk_src;
      SEL_LOCK:  src = pll_lock;
      default:   oe_o = 1'b0;
    endcase
  end

  assign pin_o = oe_o & (src ^ cfg.inv);
endmodule

// File: rtl/gpio_func_mux.sv
module gpio_func_mux
  import gpio_mux_pkg::*;
#(
  parameter int                ADDR_W    = 7,
  parameter int                DATA_W    = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 7'd8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              jack_det,
  input  logic              slow_clk_en,
  input  logic              temp_ok,
  input  logic              amute_act,
  input  logic              pll_lock,
  output logic              gpio_out,
  output logic              gpio_oe
);
  gpio_cfg_t        cfg;
  logic             div_clk;
  logic             div_hi;
  logic [DIV_W-1:0] div_act;
  logic [DIV_W-1:0] div_cnt;

  gpio_ctrl_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)
  ) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg_o(cfg)
  );

  gpio_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .div_set(cfg.div), .clk_o(div_clk),
    .hi_o(div_hi), .act_o(div_act), .cnt_o(div_cnt)
  );

  gpio_src_mux u_mux (
    .cfg(cfg), .jack_det(jack_det), .slow_clk_en(slow_clk_en),
    .temp_ok(temp_ok), .amute_act(amute_act), .pll_lock(pll_lock),
    .clk_src(div_clk), .pin_o(gpio_out), .oe_o(gpio_oe)
  );
endmodule

// File: rtl/gpio_func_mux_chk.sv
module gpio_func_mux_chk
  import gpio_mux_pkg::*;
#(
  parameter int                ADDR_W    = 7,
  parameter int                DATA_W    = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 7'd8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              slow_clk_en,
  input logic              gpio_out,
  input logic              gpio_oe,
  input gpio_cfg_t         cfg,
  input logic              div_hi,
  input logic [DIV_W-1:0]  div_act,
  input logic [DIV_W-1:0]  div_cnt
);
  AST_OFF_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !gpio_oe |-> !gpio_out); // R3

  AST_JACK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.sel == SEL_JACK && !slow_clk_en) |-> (gpio_out == cfg.inv)); // R6

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == CTRL_ADDR) |=> (cfg == $past(wr_data[CFG_W-1:0]))); // R2

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    div_cnt <= div_act); // R9

  AST_RATIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (div_cnt != div_act) |=> $stable(div_act)); // R10

  AST_DIV3_SHORT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (div_act == 2'd2 && div_hi) |=> !div_hi); // R9
endmodule

bind gpio_func_mux gpio_func_mux_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .slow_clk_en(slow_clk_en), .gpio_out(gpio_out),
  .gpio_oe(gpio_oe), .cfg(cfg), .div_hi(div_hi), .div_act(div_act),
  .div_cnt(div_cnt)
);

// File: tb/gpio_func_mux_bench.sv
`timescale 1ns/1ps
module gpio_func_mux_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [6:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        jack_det = 1'b0, slow_clk_en = 1'b0, temp_ok = 1'b0;
  logic        amute_act = 1'b0, pll_lock = 1'b0;
  logic        gpio_out, gpio_oe;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // Reference model state.
  int m_sel = 0, m_inv = 0, m_div = 0, m_act = 0, m_cnt = 0;

  always #2 clk = ~clk;

  gpio_func_mux u_gpio_func_mux (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .jack_det(jack_det), .slow_clk_en(slow_clk_en),
    .temp_ok(temp_ok), .amute_act(amute_act), .pll_lock(pll_lock),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe)
  );

  task automatic model_edge();
    if (m_cnt == m_act) begin
      m_cnt = 0;
      m_act = m_div;
    end else begin
      m_cnt = m_cnt + 1;
    end
    if (wr_en && wr_addr == 7'd8) begin
      m_sel = wr_data[2:0];
      m_inv = wr_data[3];
      m_div = wr_data[5:4];
    end
  endtask

  task automatic check(string tag, bit high_phase);
    int ratio, src, exp_oe, exp_out;
    ratio  = m_act + 1;
    exp_oe = (m_sel >= 1 && m_sel <= 5);
    case (m_sel)
      1: src = jack_det && slow_clk_en;
      2: src = temp_ok;
      3: src = amute_act;
      4: src = (ratio == 1) ? int'(high_phase) : int'(m_cnt < ratio / 2);
      5: src = pll_lock;
      default: src = 0;
    endcase
    exp_out = exp_oe ? (src ^ m_inv) : 0;
    tests++;
    if (gpio_out !== exp_out[0] || gpio_oe !== exp_oe[0]) begin
      fails++;
      $display("FAIL %s: out=%b oe=%b expected out=%0d oe=%0d (sel=%0d phase=%0d)",
               tag, gpio_out, gpio_oe, exp_out, exp_oe, m_sel, high_phase);
    end
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    if (rst_n) model_edge();
    #1 check(tag, 1'b1);
    #2 check(tag, 1'b0);
    #0.5;
  endtask

  task automatic write(string tag, logic [6:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick(tag);
    wr_en = 1'b0;
  endtask

  initial begin
    #3.5;
    tick("R1");
    rst_n = 1'b1;
    repeat (3) tick("R1");

    // R2: wrong address and upper data bits
    write("R2", 7'd9, 16'h0002);
    temp_ok = 1'b1;
    tick("R2");
    write("R2", 7'd8, 16'hFFC2);
    tick("R2");

    // R5 / R4: flag sources follow their inputs
    for (int i = 0; i < 4; i++) begin temp_ok = i[0]; tick("R5"); end
    write("R4", 7'd8, 16'h0003);
    for (int i = 0; i < 4; i++) begin amute_act = i[0]; tick("R5"); end
    write("R4", 7'd8, 16'h0005);
    for (int i = 0; i < 4; i++) begin pll_lock = ~i[0]; tick("R5"); end

    // R6: jack gated by slow clock enable
    write("R6", 7'd8, 16'h0001);
    for (int i = 0; i < 4; i++) begin
      jack_det = i[0]; slow_clk_en = i[1]; tick("R6");
    end
    write("R7", 7'd8, 16'h0009);
    for (int i = 0; i < 4; i++) begin
      jack_det = i[0]; slow_clk_en = i[1]; tick("R7");
    end

    // R7: inversion on flag sources
    write("R7", 7'd8, 16'h000A);
    for (int i = 0; i < 2; i++) begin temp_ok = i[0]; tick("R7"); end

    // R3: off and reserved codes with inversion set
    write("R3", 7'd8, 16'h0008); tick("R3");
    write("R3", 7'd8, 16'h000E); tick("R3");
    write("R3", 7'd8, 16'h000F); tick("R3");
    write("R3", 7'd8, 16'h0006); tick("R3");

    // R8: clock pass-through, then inverted
    write("R8", 7'd8, 16'h0004);
    repeat (4) tick("R8");
    write("R7", 7'd8, 16'h000C);
    repeat (4) tick("R7");

    // R9: each ratio
    write("R9", 7'd8, 16'h0014); repeat (12) tick("R9");
    write("R9", 7'd8, 16'h0024); repeat (12) tick("R9");
    write("R9", 7'd8, 16'h0034); repeat (12) tick("R9");
    write("R9", 7'd8, 16'h003C); repeat (8) tick("R9");

    // R10: ratio changes at several points inside a period
    for (int k = 0; k < 4; k++) begin
      write("R10", 7'd8, 16'h0034);
      repeat (k + 5) tick("R10");
      write("R10", 7'd8, 16'h0024);
      repeat (k + 3) tick("R10");
      write("R10", 7'd8, 16'h0014);
      repeat (k + 1) tick("R10");
      write("R10", 7'd8, 16'h0004);
      repeat (2) tick("R10");
    end

    // R1: reset mid-run returns to defaults
    rst_n = 1'b0;
    m_sel = 0; m_inv = 0; m_div = 0; m_act = 0; m_cnt = 0;
    tick("R1");
    rst_n = 1'b1;
    tick("R1");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule